// File: doc/BRIEF.md
# Eight-Point Scaled Fast DCT Pipeline

This block takes eight signed samples in parallel and returns their eight-point forward discrete cosine transform, normalised so that coefficient k is C_k · Σ x(n)·cos((2n+1)kπ/16), with C_0 = √(1/8) and C_k = √(2/8) = 1/2 for k ≥ 1. The transform is factored into add/subtract butterflies and only five constant multiplications: 0.707 is used twice, and 0.541, 1.307 and 0.383 once each. The factored graph leaves every coefficient carrying its own gain. A final constant multiply per lane removes that gain.

The datapath is a five-stage pipeline and accepts a new vector on every clock. The factored graph produces its coefficients on its output lines in a shuffled order. A per-vector select input either keeps that order or restores natural order 0 to 7. Constants and intermediate products are held in fixed point with fourteen fractional bits. Every product is rounded back to the internal width, and the outputs are clamped to 16 bits.

Top module: `dct8_fast`

## Requirements
- R1: A vector accepted with `in_valid` high at a rising edge appears with `out_valid` high exactly 5 rising edges later. Vectors presented on consecutive cycles emerge on consecutive cycles, in the order they were accepted.
- R2: Each output lane holds the coefficient C_k · Σ x(n)·cos((2n+1)kπ/16) within ±4 LSB, for any input samples in [-2048, 2047]. Sample n is the two's complement value in `in_samples[12n+11:12n]`, and lane j is the two's complement value in `out_coefs[16j+15:16j]`.
- R3: With `natural_order` low when the vector is accepted, lanes 0 to 7 carry coefficients 0, 4, 6, 2, 7, 1, 5, 3 in that order.
- R4: With `natural_order` high when the vector is accepted, lane k carries coefficient k. The select is captured with each vector, so it may change on every cycle. Coefficient 0 is on lane 0 in both orders.
- R5: When all eight input samples are equal, every coefficient other than coefficient 0 is exactly zero.
- R6: While `out_valid` is low, `out_coefs` keeps the value it last had.
- R7: After reset, and until the first result, `out_valid` is low and `out_coefs` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is valid this cycle |
| natural_order | input | 1 | 1: natural coefficient order, 0: flow-graph order |
| in_samples | input | 96 | Eight 12-bit signed samples; sample n at bits [12n+11:12n] |
| out_valid | output | 1 | Output vector is valid this cycle |
| out_coefs | output | 128 | Eight 16-bit signed coefficients; lane j at bits [16j+15:16j] |

## Verification
The checks that run on every cycle cover several properties. Valid moves forward one stage per clock. The first butterfly rank preserves the input sum. The 0.707 multiplier keeps the sign of its operand. The even pair on lines 0/1 and 3/2 matches the flow-graph order. The DC sign survives the descale on lane 0. The output is held whenever valid is low. Only the bench scenarios can show numerical accuracy against the cosine formula, the mapping of all eight lanes in each order, and the exact zeros for flat inputs. The same applies to the mode being tracked per vector when it toggles every cycle and to the absolute five-cycle latency.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

    localparam int LANES  = 8;
    localparam int ROT_N  = 9;          // values carried past the multiply rank
    localparam int COEF_W = 16;
    localparam int FRAC_W = 14;
    localparam int WIDE_W = 32;
    localparam int PROD_W = WIDE_W + COEF_W;

    // Flow-graph constants, Q1.14
    localparam logic signed [COEF_W-1:0] K_HALF_ROOT2 = 16'sd11585; // 0.707107
    localparam logic signed [COEF_W-1:0] K_ROT_A      = 16'sd8867;  // 0.541196
    localparam logic signed [COEF_W-1:0] K_ROT_B      = 16'sd21407; // 1.306563
    localparam logic signed [COEF_W-1:0] K_ROT_C      = 16'sd6270;  // 0.382683

    // Coefficient index carried on each raw flow-graph line
    function automatic int raw_coef(input int lane);
        case (lane)
            0:       return 0;
            1:       return 4;
            2:       return 6;
            3:       return 2;
            4:       return 7;
            5:       return 1;
            6:       return 5;
            default: return 3;
        endcase
    endfunction

    // Raw line that carries a given coefficient
    function automatic int raw_lane_of(input int coef);
        case (coef)
            0:       return 0;
            1:       return 5;
            2:       return 3;
            3:       return 7;
            4:       return 1;
            5:       return 6;
            6:       return 2;
            default: return 4;
        endcase
    endfunction

    // Per-coefficient gain that removes the factored graph's scaling, Q1.14
    function automatic logic signed [COEF_W-1:0] descale_gain(input int coef);
        case (coef)
            0:       return 16'sd5793;   // 1/sqrt(8)
            1:       return 16'sd4176;
            2:       return 16'sd4433;
            3:       return 16'sd4926;
            4:       return 16'sd5793;
            5:       return 16'sd7373;
            6:       return 16'sd10703;
            default: return 16'sd20995;
        endcase
    endfunction

    // Signed multiply by a Q1.14 constant, rounded to nearest
    function automatic logic signed [WIDE_W-1:0] qmul(input logic signed [WIDE_W-1:0] v,
                                                      input logic signed [COEF_W-1:0] c);
        logic signed [PROD_W-1:0] p;
        p = PROD_W'(v) * PROD_W'(c);
        p = p + (PROD_W'(1) <<< (FRAC_W - 1));
        return p[FRAC_W +: WIDE_W];
    endfunction

endpackage

// File: rtl/dct8_front.sv
module dct8_front import dct8_pkg::*; #(
    parameter int IN_W  = 12,
    parameter int INT_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_mode,
    input  logic signed [IN_W-1:0]  x [LANES],
    output logic                    b_valid,
    output logic                    b_mode,
    output logic signed [INT_W-1:0] b [LANES]
);
    typedef logic signed [INT_W-1:0] word_t;

    typedef struct packed {
        logic                  a_vld;
        logic                  a_mode;
        word_t [LANES-1:0]     a;
        logic                  b_vld;
        logic                  b_mode;
        word_t [LANES-1:0]     b;
    } front_t;

    front_t st_d, st_q;
    word_t  in_sum;

    always_comb begin
        st_d        = st_q;
        // rank A: mirror butterflies, sums low, differences high (reversed)
        st_d.a_vld  = in_valid;
        st_d.a_mode = in_mode;
        for (int i = 0; i < LANES/2; i++) begin
            st_d.a[i]         = word_t'(x[i]) + word_t'(x[LANES-1-i]);
            st_d.a[LANES-1-i] = word_t'(x[i]) - word_t'(x[LANES-1-i]);
        end
        // rank B: even half butterflies, odd half adjacent sums
        st_d.b_vld  = st_q.a_vld;
        st_d.b_mode = st_q.a_mode;
        st_d.b[0]   = st_q.a[0] + st_q.a[3];
        st_d.b[1]   = st_q.a[1] + st_q.a[2];
        st_d.b[2]   = st_q.a[1] - st_q.a[2];
        st_d.b[3]   = st_q.a[0] - st_q.a[3];
        st_d.b[4]   = st_q.a[4] + st_q.a[5];
        st_d.b[5]   = st_q.a[5] + st_q.a[6];
        st_d.b[6]   = st_q.a[6] + st_q.a[7];
        st_d.b[7]   = st_q.a[7];
    end

    always_comb begin
        in_sum = '0;
        for (int i = 0; i < LANES; i++) in_sum = in_sum + word_t'(x[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign b_valid = st_q.b_vld;
    assign b_mode  = st_q.b_mode;
    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign b[g] = st_q.b[g];
    end

    // R1: valid advances one rank per clock
    assert_valid_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.b_vld == $past(st_q.a_vld));

    // R2: the sum half of rank A preserves the total of the inputs
    assert_rank_a_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.a_vld |-> (st_q.a[0] + st_q.a[1] + st_q.a[2] + st_q.a[3]) == $past(in_sum));

endmodule

// File: rtl/dct8_rotate.sv
module dct8_rotate import dct8_pkg::*; #(
    parameter int INT_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    b_valid,
    input  logic                    b_mode,
    input  logic signed [INT_W-1:0] b [LANES],
    output logic                    c_valid,
    output logic                    c_mode,
    output logic signed [INT_W-1:0] c [ROT_N]
);
    typedef logic signed [INT_W-1:0] word_t;

    typedef struct packed {
        logic              vld;
        logic              mode;
        word_t [ROT_N-1:0] c;
    } rot_t;

    rot_t st_d, st_q;

    function automatic word_t mulk(input word_t v, input logic signed [COEF_W-1:0] k);
        return word_t'(qmul(WIDE_W'(v), k));
    endfunction

    // c: 0 even sum, 1 even sum', 2 even diff, 3 even rotation,
    //    4 odd pass-through, 5 odd centre product, 6..8 odd rotation terms
    always_comb begin
        st_d      = st_q;
        st_d.vld  = b_valid;
        st_d.mode = b_mode;
        st_d.c[0] = b[0];
        st_d.c[1] = b[1];
        st_d.c[2] = b[3];
        st_d.c[3] = mulk(b[2] + b[3], K_HALF_ROOT2);
        st_d.c[4] = b[7];
        st_d.c[5] = mulk(b[5], K_HALF_ROOT2);
        st_d.c[6] = mulk(b[4], K_ROT_A);
        st_d.c[7] = mulk(b[6], K_ROT_B);
        st_d.c[8] = mulk(b[4] - b[6], K_ROT_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign c_valid = st_q.vld;
    assign c_mode  = st_q.mode;
    for (genvar g = 0; g < ROT_N; g++) begin : g_out
        assign c[g] = st_q.c[g];
    end

    // R1: valid advances one rank per clock
    assert_valid_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld == $past(b_valid));

    // R2: a positive constant keeps the operand's sign
    assert_rotation_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(b[2] + b[3]) > 0) |-> st_q.c[3] >= 0);

endmodule

// File: rtl/dct8_merge.sv
module dct8_merge import dct8_pkg::*; #(
    parameter int INT_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    c_valid,
    input  logic                    c_mode,
    input  logic signed [INT_W-1:0] c [ROT_N],
    output logic                    d_valid,
    output logic                    d_mode,
    output logic signed [INT_W-1:0] d [LANES]
);
    typedef logic signed [INT_W-1:0] word_t;

    typedef struct packed {
        logic              vld;
        logic              mode;
        word_t [LANES-1:0] d;
    } merge_t;

    merge_t st_d, st_q;
    word_t  odd_lo, odd_hi, odd_p, odd_m;

    always_comb begin
        odd_lo    = c[6] + c[8];
        odd_hi    = c[7] + c[8];
        odd_p     = c[4] + c[5];
        odd_m     = c[4] - c[5];
        st_d      = st_q;
        st_d.vld  = c_valid;
        st_d.mode = c_mode;
        // raw line order carries coefficients 0,4,6,2,7,1,5,3
        st_d.d[0] = c[0] + c[1];
        st_d.d[1] = c[0] - c[1];
        st_d.d[2] = c[2] - c[3];
        st_d.d[3] = c[2] + c[3];
        st_d.d[4] = odd_p - odd_hi;
        st_d.d[5] = odd_p + odd_hi;
        st_d.d[6] = odd_m + odd_lo;
        st_d.d[7] = odd_m - odd_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_valid = st_q.vld;
    assign d_mode  = st_q.mode;
    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign d[g] = st_q.d[g];
    end

    // R1: valid advances one rank per clock
    assert_valid_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld == $past(c_valid));

    // R3: lines 0/1 form the DC/Nyquist pair of the even sums
    assert_even_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.d[0] + st_q.d[1]) == ($past(c[0]) <<< 1));

    // R3: lines 3/2 form the pair around the even rotation
    assert_rot_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.d[3] - st_q.d[2]) == ($past(c[3]) <<< 1));

endmodule

// File: rtl/dct8_descale.sv
module dct8_descale import dct8_pkg::*; #(
    parameter int INT_W = 20,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    d_valid,
    input  logic                    d_mode,
    input  logic signed [INT_W-1:0] d [LANES],
    output logic                    y_valid,
    output logic signed [OUT_W-1:0] y [LANES]
);
    typedef logic signed [INT_W-1:0] word_t;
    typedef logic signed [OUT_W-1:0] out_t;

    localparam word_t SAT_HI = word_t'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam word_t SAT_LO = word_t'(-(64'sd1 <<< (OUT_W - 1)));

    typedef struct packed {
        logic             vld;
        out_t [LANES-1:0] y;
    } desc_t;

    desc_t st_d, st_q;
    out_t  scaled [LANES];

    function automatic out_t clamp(input word_t v);
        if (v > SAT_HI)      return out_t'(SAT_HI);
        else if (v < SAT_LO) return out_t'(SAT_LO);
        else                 return out_t'(v);
    endfunction

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic signed [COEF_W-1:0] GAIN = descale_gain(raw_coef(g));
        word_t prod;
        assign prod      = word_t'(qmul(WIDE_W'(d[g]), GAIN));
        assign scaled[g] = clamp(prod);
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = d_valid;
        if (d_valid) begin
            for (int s = 0; s < LANES; s++) begin
                st_d.y[s] = d_mode ? scaled[raw_lane_of(s)] : scaled[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_valid = st_q.vld;
    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign y[g] = st_q.y[g];
    end

    // R6: lanes do not move while no result is being presented
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld |-> $stable(st_q.y));

    // R4: lane 0 carries the DC term in both orders, sign preserved
    assert_dc_lane_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(d[0]) > word_t'(2)) |-> st_q.y[0] > 0);

    assert_dc_lane_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(d[0]) < -word_t'(2)) |-> st_q.y[0] < 0);

endmodule

// File: rtl/dct8_fast.sv
module dct8_fast import dct8_pkg::*; #(
    parameter int IN_W  = 12,
    parameter int INT_W = 20,
    parameter int OUT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     natural_order,
    input  logic [LANES*IN_W-1:0]    in_samples,
    output logic                     out_valid,
    output logic [LANES*OUT_W-1:0]   out_coefs
);
    logic signed [IN_W-1:0]  x_lane [LANES];
    logic signed [INT_W-1:0] b_vec  [LANES];
    logic signed [INT_W-1:0] c_vec  [ROT_N];
    logic signed [INT_W-1:0] d_vec  [LANES];
    logic signed [OUT_W-1:0] y_vec  [LANES];
    logic b_valid, b_mode, c_valid, c_mode, d_valid, d_mode;

    for (genvar g = 0; g < LANES; g++) begin : g_io
        assign x_lane[g]                  = in_samples[g*IN_W +: IN_W];
        assign out_coefs[g*OUT_W +: OUT_W] = y_vec[g];
    end

    dct8_front #(.IN_W(IN_W), .INT_W(INT_W)) u_front (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_mode(natural_order), .x(x_lane),
        .b_valid(b_valid), .b_mode(b_mode), .b(b_vec)
    );

    dct8_rotate #(.INT_W(INT_W)) u_rotate (
        .clk(clk), .rst_n(rst_n),
        .b_valid(b_valid), .b_mode(b_mode), .b(b_vec),
        .c_valid(c_valid), .c_mode(c_mode), .c(c_vec)
    );

    dct8_merge #(.INT_W(INT_W)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .c_valid(c_valid), .c_mode(c_mode), .c(c_vec),
        .d_valid(d_valid), .d_mode(d_mode), .d(d_vec)
    );

    dct8_descale #(.INT_W(INT_W), .OUT_W(OUT_W)) u_descale (
        .clk(clk), .rst_n(rst_n),
        .d_valid(d_valid), .d_mode(d_mode), .d(d_vec),
        .y_valid(out_valid), .y(y_vec)
    );

endmodule

// File: tb/dct8_fast_bench.sv
`timescale 1ns/1ps
module dct8_fast_bench;

    localparam int NL   = 8;
    localparam int IW   = 12;
    localparam int OW   = 16;
    localparam int LAT  = 5;
    localparam real PI  = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               natural_order = 1'b0;
    logic [NL*IW-1:0]   in_samples = '0;
    logic               out_valid;
    logic [NL*OW-1:0]   out_coefs;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;
    logic [NL*OW-1:0] last_out = '0;

    real   exp_q [$];
    real   tol_q [$];
    string tag_q [$];
    int    due_q [$];

    int RAW_ORDER [NL] = '{0, 4, 6, 2, 7, 1, 5, 3};

    dct8_fast u_dct8_fast (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .natural_order(natural_order),
        .in_samples(in_samples), .out_valid(out_valid), .out_coefs(out_coefs)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic real ref_coef(input int xs [NL], input int k);
        real acc;
        acc = 0.0;
        for (int n = 0; n < NL; n++) acc = acc + xs[n] * $cos((2*n + 1) * k * PI / 16.0);
        return (k == 0 ? $sqrt(0.125) : 0.5) * acc;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: presents one vector and queues what must come out
    task automatic send(input int xs [NL], input bit nat, input bit flat);
        @(negedge clk);
        for (int i = 0; i < NL; i++) in_samples[i*IW +: IW] = xs[i][IW-1:0];
        natural_order = nat;
        in_valid      = 1'b1;
        due_q.push_back(cyc + LAT);
        for (int s = 0; s < NL; s++) begin
            int k;
            k = nat ? s : RAW_ORDER[s];
            exp_q.push_back(ref_coef(xs, k));
            tol_q.push_back((flat && k != 0) ? 0.25 : 4.0);
            if (flat)     tag_q.push_back("R5");
            else if (nat) tag_q.push_back("R2 R4");
            else          tag_q.push_back("R2 R3");
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (rst_n && armed) begin
            if (out_valid) begin
                checks++;
                if (due_q.size() == 0) begin
                    errors++;
                    $display("FAIL R1: unexpected result at cycle %0d (actual valid 1, expected 0)", cyc);
                end else begin
                    int due;
                    due = due_q.pop_front();
                    if (cyc != due) begin
                        errors++;
                        $display("FAIL R1: result at cycle %0d, expected cycle %0d", cyc, due);
                    end
                end
                for (int s = 0; s < NL; s++) begin
                    int    act;
                    real   e, t, diff;
                    string tg;
                    act = int'($signed(out_coefs[s*OW +: OW]));
                    if (exp_q.size() > 0) begin
                        e  = exp_q.pop_front();
                        t  = tol_q.pop_front();
                        tg = tag_q.pop_front();
                        diff = act - e;
                        if (diff < 0.0) diff = -diff;
                        checks++;
                        if (diff > t) begin
                            errors++;
                            $display("FAIL %s: lane %0d actual %0d expected %f (tol %f)", tg, s, act, e, t);
                        end
                    end
                end
                last_out = out_coefs;
            end else begin
                checks++;
                if (out_coefs !== last_out) begin
                    errors++;
                    $display("FAIL R6: idle output actual %h expected %h", out_coefs, last_out);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired, actual pending %0d expected 0", due_q.size());
            finish_run();
        end
    end

    initial begin
        int xs [NL];
        int unsigned lfsr;
        lfsr = 32'h1234_5678;

        repeat (3) @(negedge clk);
        // R7: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R7: out_valid actual %b expected 0", out_valid);
        end
        checks++;
        if (out_coefs !== '0) begin
            errors++;
            $display("FAIL R7: out_coefs actual %h expected 0", out_coefs);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;
        idle(2);

        // R3: impulses on each sample, back to back, flow-graph order
        for (int n = 0; n < NL; n++) begin
            for (int i = 0; i < NL; i++) xs[i] = (i == n) ? 1000 : 0;
            send(xs, 1'b0, 1'b0);
        end
        idle(3);

        // R4: impulses with gaps, natural order
        for (int n = 0; n < NL; n++) begin
            for (int i = 0; i < NL; i++) xs[i] = (i == n) ? -1500 : 0;
            send(xs, 1'b1, 1'b0);
            idle(n % 3);
        end
        idle(3);

        // R5: flat inputs, both orders, including the extremes
        for (int i = 0; i < NL; i++) xs[i] = 2047;
        send(xs, 1'b0, 1'b1);
        for (int i = 0; i < NL; i++) xs[i] = -2048;
        send(xs, 1'b1, 1'b1);
        for (int i = 0; i < NL; i++) xs[i] = 5;
        send(xs, 1'b0, 1'b1);
        for (int i = 0; i < NL; i++) xs[i] = 0;
        send(xs, 1'b1, 1'b1);
        idle(4);

        // R2: alternating full-scale and a ramp
        for (int i = 0; i < NL; i++) xs[i] = (i % 2 == 0) ? 2047 : -2048;
        send(xs, 1'b0, 1'b0);
        send(xs, 1'b1, 1'b0);
        for (int i = 0; i < NL; i++) xs[i] = -1400 + 400 * i;
        send(xs, 1'b1, 1'b0);
        send(xs, 1'b0, 1'b0);
        idle(2);

        // R2 R4: pseudo-random vectors, order select toggling every cycle
        for (int v = 0; v < 48; v++) begin
            for (int i = 0; i < NL; i++) begin
                lfsr = lfsr ^ (lfsr << 13);
                lfsr = lfsr ^ (lfsr >> 17);
                lfsr = lfsr ^ (lfsr << 5);
                xs[i] = int'(lfsr & 32'hFFF);
                if (xs[i] > 2047) xs[i] = xs[i] - 4096;
            end
            send(xs, v[0], 1'b0);
        end
        idle(LAT + 6);

        // R1: every queued vector emerged
        checks++;
        if (due_q.size() != 0 || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: pending results actual %0d expected 0", due_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule